// File: doc/BRIEF.md
# TV Audio Decoder Control Slave

This block is the serial control port of a broadcast TV audio decoder. It sits on a two-wire I2C bus as a slave, samples SCL and SDA with the system clock, and recognises START, repeated START and STOP from SDA edges that occur while SCL is high. A write carries a sub-address byte and then one or more data bytes. The bytes go into a small bank of control registers, and the sub-address moves up by one after every data byte. The register fields are decoded into separate output pins that drive the decoder's mode-control logic.

A read carries no sub-address. It returns one status byte built from the live stereo, second-program and noise detector flags, together with a sticky power-on flag. The power-on flag is set by reset and cleared once a status byte has been fully read. The slave only ever pulls SDA low: for an acknowledge, or for a zero bit of read data. At all other times it leaves the line released.

Top module: `tvdec_i2c_ctrl`

## Requirements
- R1: The slave responds only to the 7-bit address 0x42. The address byte 0x84 (write) or 0x85 (read) is acknowledged (SDA low in the ninth clock). Any other address byte is not acknowledged, and the slave then ignores the bus until the next START.
- R2: A write is address byte, sub-address byte, then data bytes. Every byte is acknowledged while the register pointer is in range. Each data byte goes into the register the pointer selects, and the pointer then moves up by one, so a burst fills consecutive registers.
- R3: Only sub-address bits 3:0 form the pointer, and bits 7:4 are ignored. Registers exist at pointer 0 to 4 only. A data byte aimed at pointer 5 to 15 is not acknowledged and changes no output. The pointer still advances, wrapping from 15 to 0.
- R4: After reset the fields are: in_gain=9, sep_hf=0x1F, sep_lf=0x1F, unmute=1, and every other field 0.
- R5: Field positions are as follows. Register 0: bit1 test_dac, bit0 test_flt. Register 1: bits 5:0 sep_hf. Register 2: bits 5:0 sep_lf. Register 3: bit7 ext_mono2, bit6 ext_mono1, bit5 out_ext, bit4 ext_sel, bit3 prog_sel, bit2 force_mono, bit1 prog_force, bit0 unmute. Register 4: bit7 in_lvl_sel, bit6 aux_prog_sel, bit5 bypass_agc, bit4 force_st, bits 3:0 in_gain.
- R6: The status byte reads as bit7 det_sap, bit6 det_noise, bit1 power-on flag, bit0 det_stereo, with bits 5:2 at zero. It is sent MSB first, and the detector values are taken when the byte starts.
- R7: The power-on flag is 1 after reset. It clears when the master clocks the acknowledge bit that follows a status byte, and it stays 0 from then on.
- R8: The slave pulls SDA low only during an acknowledge it gives or during a zero read-data bit. It never pulls SDA while the master sends bits, and never after a NACK.
- R9: A START, including a repeated START in the middle of a transfer, restarts address reception. A STOP abandons a partly received byte without writing it.
- R10: If the master acknowledges a status byte, the status byte is sent again. A master NACK ends the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the board |
| sda_i | input | 1 | Bus data line as seen on the board |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| det_stereo | input | 1 | Pilot (stereo) detected |
| det_sap | input | 1 | Second audio program carrier detected |
| det_noise | input | 1 | Excess noise detected on the second program |
| in_gain | output | 4 | Input level trim |
| sep_hf | output | 6 | High-frequency separation trim |
| sep_lf | output | 6 | Low-frequency separation trim |
| test_dac | output | 1 | Trim-DAC test mode |
| test_flt | output | 1 | Filter test mode |
| force_st | output | 1 | Force stereo decoding |
| out_ext | output | 1 | TV output taken from an external input |
| ext_sel | output | 1 | Which external input (0 first, 1 second) |
| ext_mono1 | output | 1 | Force first external input to mono |
| ext_mono2 | output | 1 | Force second external input to mono |
| prog_sel | output | 1 | Select second program instead of stereo |
| force_mono | output | 1 | Force mono output |
| prog_force | output | 1 | Select second program even without carrier |
| unmute | output | 1 | 1 lets the TV output through, 0 mutes it |
| in_lvl_sel | output | 1 | Nominal input level select |
| aux_prog_sel | output | 1 | Auxiliary output carries second program |
| bypass_agc | output | 1 | Bypass the input level amplifier |

## Verification
The burst writes cover several starting points and lengths: bursts that start at pointer 0 and run across the whole bank, bursts whose sub-address byte has its upper nibble set, and bursts that run past register 4 into the empty pointer range and wrap. Together these separate correct pointer advance from a pointer that is mis-latched or fails to wrap. A foreign address, a repeated START between a write and a read, and a STOP in the middle of a byte show whether framing is detected at the right moment. Reads with a master ACK and with a master NACK, under changing detector flags, show whether the status byte is captured fresh each time and whether the power-on flag clears at the right point. Random transactions from a fixed seed mix all of these together.

// File: rtl/tvdec_i2c_pkg.sv
// Package: shared types and constants for the TV decoder control slave.
// Assumes at most eight registers of at most eight bits each.
package tvdec_i2c_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_SUB,
        S_WDAT,
        S_ACK,
        S_RDAT,
        S_MACK
    } i2c_state_e;

    // Number of bits each register actually stores
    function automatic int reg_width(input int idx);
        case (idx)
            0:       return 2;
            1, 2:    return 6;
            default: return 8;
        endcase
    endfunction

    // Bit offset of a register inside the packed field vector
    function automatic int reg_offset(input int idx);
        int sum;
        sum = 0;
        for (int k = 0; k < idx; k++) sum += reg_width(k);
        return sum;
    endfunction

    // Value each register takes at reset
    function automatic logic [7:0] reg_reset_val(input int idx);
        case (idx)
            1, 2:    return 8'h1F;
            3:       return 8'h01;
            4:       return 8'h09;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/i2c_bus_sync.sv
// Module: i2c_bus_sync
// Brings SCL and SDA into the clock domain through STAGES flops each, then
// flags SCL edges and START/STOP (SDA edges while SCL stays high).
// Assumes the system clock is many times faster than the bus.
module i2c_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_q, sda_q, scl_s;

    // Synchronizer chains, idle-high at reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    // One-cycle history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_slave_fsm.sv
// Module: i2c_slave_fsm
// Byte engine of the slave. It receives the address, sub-address and data
// bytes, gives acknowledges, shifts the status byte out and raises one-cycle
// write and power-on-clear strobes. Assumes the edge flags of i2c_bus_sync.
module i2c_slave_fsm
    import tvdec_i2c_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h42,
    parameter int         SUB_W      = 4,
    parameter int         NUM_REGS   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [7:0]       status_byte,
    output logic             sda_oe,
    output logic             wr_en,
    output logic [SUB_W-1:0] wr_addr,
    output logic [7:0]       wr_data,
    output logic             por_clr
);
    localparam logic [SUB_W:0] NREG = (SUB_W+1)'(NUM_REGS);

    i2c_state_e       state, nxt_state;
    logic [3:0]       bitcnt;
    logic [7:0]       shreg;
    logic [6:0]       txreg;
    logic [SUB_W-1:0] ptr;
    logic             mack;
    logic             ptr_valid;

    assign ptr_valid = ({1'b0, ptr} < NREG);

    // Bus protocol sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            nxt_state <= S_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            txreg     <= '0;
            ptr       <= '0;
            mack      <= 1'b0;
            sda_oe    <= 1'b0;
            wr_en     <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            por_clr   <= 1'b0;
        end else begin
            wr_en   <= 1'b0;
            por_clr <= 1'b0;
            if (start_det) begin
                state  <= S_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state  <= S_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    S_ADDR, S_SUB, S_WDAT: begin
                        if (scl_rise && bitcnt < 4'd8) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            if (state == S_ADDR) begin
                                if (shreg[7:1] == SLAVE_ADDR) begin
                                    sda_oe    <= 1'b1;
                                    state     <= S_ACK;
                                    nxt_state <= shreg[0] ? S_RDAT : S_SUB;
                                end else begin
                                    state <= S_IDLE;
                                end
                            end else if (state == S_SUB) begin
                                ptr       <= shreg[SUB_W-1:0];
                                sda_oe    <= 1'b1;
                                state     <= S_ACK;
                                nxt_state <= S_WDAT;
                            end else begin
                                if (ptr_valid) begin
                                    sda_oe  <= 1'b1;
                                    wr_en   <= 1'b1;
                                    wr_addr <= ptr;
                                    wr_data <= shreg;
                                end
                                ptr       <= ptr + 1'b1;
                                state     <= S_ACK;
                                nxt_state <= S_WDAT;
                            end
                        end
                    end
                    S_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            state  <= nxt_state;
                            if (nxt_state == S_RDAT) begin
                                txreg  <= status_byte[6:0];
                                sda_oe <= ~status_byte[7];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    S_RDAT: begin
                        if (scl_rise) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                state  <= S_MACK;
                            end else begin
                                sda_oe <= ~txreg[6];
                                txreg  <= {txreg[5:0], 1'b0};
                            end
                        end
                    end
                    S_MACK: begin
                        if (scl_rise) begin
                            por_clr <= 1'b1;
                            mack    <= ~sda_s;
                        end else if (scl_fall) begin
                            if (mack) begin
                                txreg  <= status_byte[6:0];
                                sda_oe <= ~status_byte[7];
                                bitcnt <= '0;
                                state  <= S_RDAT;
                            end else begin
                                state <= S_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R8: the drive only moves on an SCL fall or on bus framing
    a_r8_oe_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));

    // R1: a foreign address leaves the bus released and the engine idle
    a_r1_foreign_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ADDR && scl_fall && bitcnt == 4'd8 && shreg[7:1] != SLAVE_ADDR
         && !start_det && !stop_det) |=> (state == S_IDLE && !sda_oe));

    // R9: any START restarts address reception with SDA released
    a_r9_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == S_ADDR && bitcnt == 4'd0 && !sda_oe));

    // R10: the master's acknowledge slot is never driven by the slave
    a_r10_mack_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_MACK) |-> !sda_oe);

endmodule

// File: rtl/tvdec_ctrl_regs.sv
// Module: tvdec_ctrl_regs
// Control register bank (one generate slice per register, each only as wide
// as its fields), packed field vector, status byte and sticky power-on flag.
// Assumes write strobes arrive only for pointers inside the bank.
module tvdec_ctrl_regs
    import tvdec_i2c_pkg::*;
#(
    parameter int NUM_REGS = 5,
    parameter int SUB_W    = 4,
    localparam int CTRL_W  = reg_offset(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SUB_W-1:0]  wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              por_clr,
    input  logic              det_stereo,
    input  logic              det_sap,
    input  logic              det_noise,
    output logic [7:0]        status_byte,
    output logic [CTRL_W-1:0] ctl_bits
);
    localparam logic [SUB_W:0] NREG = (SUB_W+1)'(NUM_REGS);

    logic por_q;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam int         W   = reg_width(i);
        localparam int         OFF = reg_offset(i);
        localparam logic [7:0] RV  = reg_reset_val(i);
        logic [W-1:0] q;

        // Register slice i: reset value, then bus writes
        always_ff @(posedge clk) begin
            if (!rst_n)                                   q <= RV[W-1:0];
            else if (wr_en && wr_addr == SUB_W'(i))       q <= wr_data[W-1:0];
        end

        assign ctl_bits[OFF +: W] = q;
    end

    // Sticky power-on flag: set by reset, cleared by a finished status read
    always_ff @(posedge clk) begin
        if (!rst_n)       por_q <= 1'b1;
        else if (por_clr) por_q <= 1'b0;
    end

    assign status_byte = {det_sap, det_noise, 4'b0000, por_q, det_stereo};

    // R3: writes never reach beyond the bank
    a_r3_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ({1'b0, wr_addr} < NREG));

    // R7: a finished read clears the flag
    a_r7_por_clears: assert property (@(posedge clk) disable iff (!rst_n)
        por_clr |=> !por_q);

    // R7: once cleared the flag stays clear
    a_r7_por_stays_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !por_q |=> !por_q);

endmodule

// File: rtl/tvdec_i2c_ctrl.sv
// Module: tvdec_i2c_ctrl (top)
// Control and status slave of a TV audio decoder. It ties the bus
// synchronizer, the byte engine and the register bank together and splits the
// packed register contents into named field outputs. Assumes an open-drain
// SDA, so sda_oe=1 means pull low.
module tvdec_i2c_ctrl
    import tvdec_i2c_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR  = 7'h42,
    parameter int         SYNC_STAGES = 2,
    parameter int         SUB_W       = 4,
    parameter int         NUM_REGS    = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic       det_stereo,
    input  logic       det_sap,
    input  logic       det_noise,
    output logic [3:0] in_gain,
    output logic [5:0] sep_hf,
    output logic [5:0] sep_lf,
    output logic       test_dac,
    output logic       test_flt,
    output logic       force_st,
    output logic       out_ext,
    output logic       ext_sel,
    output logic       ext_mono1,
    output logic       ext_mono2,
    output logic       prog_sel,
    output logic       force_mono,
    output logic       prog_force,
    output logic       unmute,
    output logic       in_lvl_sel,
    output logic       aux_prog_sel,
    output logic       bypass_agc
);
    localparam int CTRL_W = reg_offset(NUM_REGS);

    logic             sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0]       status_byte;
    logic             wr_en, por_clr;
    logic [SUB_W-1:0] wr_addr;
    logic [7:0]       wr_data;
    logic [CTRL_W-1:0] ctl_bits;

    i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_slave_fsm #(
        .SLAVE_ADDR (SLAVE_ADDR),
        .SUB_W      (SUB_W),
        .NUM_REGS   (NUM_REGS)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sda_s       (sda_s),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .status_byte (status_byte),
        .sda_oe      (sda_oe),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .por_clr     (por_clr)
    );

    tvdec_ctrl_regs #(
        .NUM_REGS (NUM_REGS),
        .SUB_W    (SUB_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .por_clr     (por_clr),
        .det_stereo  (det_stereo),
        .det_sap     (det_sap),
        .det_noise   (det_noise),
        .status_byte (status_byte),
        .ctl_bits    (ctl_bits)
    );

    // Field split (register layout of R5)
    assign test_flt     = ctl_bits[0];
    assign test_dac     = ctl_bits[1];
    assign sep_hf       = ctl_bits[7:2];
    assign sep_lf       = ctl_bits[13:8];
    assign unmute       = ctl_bits[14];
    assign prog_force   = ctl_bits[15];
    assign force_mono   = ctl_bits[16];
    assign prog_sel     = ctl_bits[17];
    assign ext_sel      = ctl_bits[18];
    assign out_ext      = ctl_bits[19];
    assign ext_mono1    = ctl_bits[20];
    assign ext_mono2    = ctl_bits[21];
    assign in_gain      = ctl_bits[25:22];
    assign force_st     = ctl_bits[26];
    assign bypass_agc   = ctl_bits[27];
    assign aux_prog_sel = ctl_bits[28];
    assign in_lvl_sel   = ctl_bits[29];

endmodule

// File: tb/test_tvdec_i2c_ctrl.sv
module test_tvdec_i2c_ctrl;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic det_stereo = 1'b0, det_sap = 1'b0, det_noise = 1'b0;
    logic sda_oe;
    logic [3:0] in_gain;
    logic [5:0] sep_hf, sep_lf;
    logic test_dac, test_flt, force_st, out_ext, ext_sel, ext_mono1, ext_mono2;
    logic prog_sel, force_mono, prog_force, unmute, in_lvl_sel, aux_prog_sel, bypass_agc;
    wire  sda_line = sda_m & ~sda_oe;

    int n_chk = 0, n_fail = 0;
    logic [7:0] m [0:4];
    logic [7:0] wbuf [0:7];
    logic por_exp;
    logic oe_bad;

    always #2.5 clk = ~clk;

    tvdec_i2c_ctrl i_tvdec_i2c_ctrl (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .det_stereo(det_stereo), .det_sap(det_sap), .det_noise(det_noise),
        .in_gain(in_gain), .sep_hf(sep_hf), .sep_lf(sep_lf), .test_dac(test_dac),
        .test_flt(test_flt), .force_st(force_st), .out_ext(out_ext), .ext_sel(ext_sel),
        .ext_mono1(ext_mono1), .ext_mono2(ext_mono2), .prog_sel(prog_sel),
        .force_mono(force_mono), .prog_force(prog_force), .unmute(unmute),
        .in_lvl_sel(in_lvl_sel), .aux_prog_sel(aux_prog_sel), .bypass_agc(bypass_agc)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // Expected field vector from the model, per the R5 layout
    function automatic logic [29:0] exp_fields();
        return {m[4], m[3], m[2][5:0], m[1][5:0], m[0][1:0]};
    endfunction

    function automatic logic [29:0] got_fields();
        return {in_lvl_sel, aux_prog_sel, bypass_agc, force_st, in_gain,
                ext_mono2, ext_mono1, out_ext, ext_sel, prog_sel, force_mono, prog_force, unmute,
                sep_lf, sep_hf, test_dac, test_flt};
    endfunction

    function automatic logic [7:0] exp_status();
        return {det_sap, det_noise, 4'b0000, por_exp, det_stereo};
    endfunction

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_q();
            scl_m = 1'b1; wait_q();
            if (sda_oe) oe_bad = 1'b1;
            wait_q();
            scl_m = 1'b0; wait_q();
        end
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        ack = (sda_line == 1'b0);
        wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            wait_q();
            scl_m = 1'b1; wait_q();
            b = {b[6:0], sda_line};
            wait_q();
            scl_m = 1'b0;
        end
        wait_q();
        sda_m = give_ack ? 1'b0 : 1'b1; wait_q();
        scl_m = 1'b1; wait_q(); wait_q();
        scl_m = 1'b0; wait_q();
        sda_m = 1'b1;
    endtask

    task automatic do_write(input logic [7:0] abyte, input logic [7:0] sub, input int n, input string tag);
        logic ack;
        logic [3:0] ptr;
        bus_start();
        send_byte(abyte, ack);
        chk("R1", {tag, " address ack"}, 32'(ack), 32'(abyte == 8'h84));
        if (ack) begin
            send_byte(sub, ack);
            chk("R2", {tag, " sub-address ack"}, 32'(ack), 32'd1);
            ptr = sub[3:0];
            for (int i = 0; i < n; i++) begin
                send_byte(wbuf[i], ack);
                chk("R3", {tag, " data ack by pointer range"}, 32'(ack), 32'(ptr < 4'd5));
                if (ptr < 4'd5) m[ptr] = wbuf[i];
                ptr = ptr + 4'd1;
            end
        end else begin
            send_byte(wbuf[0], ack);
            chk("R1", {tag, " byte after foreign address ignored"}, 32'(ack), 32'd0);
        end
        bus_stop();
        wait_q();
        chk("R2", {tag, " register fields"}, 32'(got_fields()), 32'(exp_fields()));
    endtask

    task automatic do_read(input int nbytes, input string tag);
        logic ack;
        logic [7:0] b;
        bus_start();
        send_byte(8'h85, ack);
        chk("R1", {tag, " read address ack"}, 32'(ack), 32'd1);
        for (int k = 0; k < nbytes; k++) begin
            recv_byte(k < nbytes - 1, b);
            chk("R6", {tag, " status byte"}, 32'(b), 32'(exp_status()));
            por_exp = 1'b0;
        end
        chk("R8", {tag, " line released after NACK"}, 32'(sda_oe), 32'd0);
        bus_stop();
        wait_q();
    endtask

    initial begin
        logic ack;
        logic [7:0] b;
        int dummy;
        oe_bad = 1'b0;
        por_exp = 1'b1;
        m[0] = 8'h00; m[1] = 8'h1F; m[2] = 8'h1F; m[3] = 8'h01; m[4] = 8'h09;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R4: reset values
        chk("R4", "reset fields", 32'(got_fields()), 32'(exp_fields()));
        chk("R4", "unmute at reset", 32'(unmute), 32'd1);
        chk("R8", "idle release", 32'(sda_oe), 32'd0);

        // R6 / R7: first read shows power-on flag, second shows it cleared
        det_sap = 1'b1; det_stereo = 1'b1; det_noise = 1'b0;
        do_read(1, "R7 first read");
        chk("R7", "flag model cleared", 32'(por_exp), 32'd0);
        do_read(1, "R7 second read");

        // R10: master ACK repeats status with fresh detector values
        det_sap = 1'b0; det_stereo = 1'b0; det_noise = 1'b1;
        do_read(3, "R10 repeated status");

        // R2: full burst from pointer 0
        wbuf[0] = 8'h03; wbuf[1] = 8'h2C; wbuf[2] = 8'h11; wbuf[3] = 8'h5A; wbuf[4] = 8'hF4;
        do_write(8'h84, 8'h00, 5, "R2 burst 0..4");
        // R5: single field positions
        chk("R5", "unmute from reg3 bit0", 32'(unmute), 32'd0);
        chk("R5", "ext_sel from reg3 bit4", 32'(ext_sel), 32'd1);
        chk("R5", "force_st from reg4 bit4", 32'(force_st), 32'd1);
        chk("R5", "in_gain from reg4 bits 3:0", 32'(in_gain), 32'd4);

        // R3: upper nibble of sub-address ignored
        wbuf[0] = 8'hA5;
        do_write(8'h84, 8'hF3, 1, "R3 upper nibble");
        chk("R3", "ext_mono2 after 0xF3 write", 32'(ext_mono2), 32'd1);

        // R3: burst running off the end of the bank and wrapping
        wbuf[0] = 8'h29; wbuf[1] = 8'hFF; wbuf[2] = 8'h00;
        do_write(8'h84, 8'h04, 3, "R3 past end");
        wbuf[0] = 8'h77; wbuf[1] = 8'h02;
        do_write(8'h84, 8'h0F, 2, "R3 wrap 15->0");

        // R1: foreign address
        wbuf[0] = 8'h00;
        do_write(8'h86, 8'h00, 1, "R1 foreign");

        // R9: repeated START between write and read
        bus_start();
        send_byte(8'h84, ack);
        send_byte(8'h01, ack);
        send_byte(8'h2A, ack);
        chk("R9", "data ack before repeated start", 32'(ack), 32'd1);
        m[1] = 8'h2A;
        bus_start();
        send_byte(8'h85, ack);
        chk("R9", "address ack after repeated start", 32'(ack), 32'd1);
        recv_byte(1'b0, b);
        chk("R9", "status after repeated start", 32'(b), 32'(exp_status()));
        bus_stop();
        wait_q();
        chk("R9", "fields after repeated start", 32'(got_fields()), 32'(exp_fields()));

        // R9: STOP in the middle of a data byte writes nothing
        bus_start();
        send_byte(8'h84, ack);
        send_byte(8'h02, ack);
        for (int i = 0; i < 4; i++) begin
            sda_m = 1'b1; wait_q();
            scl_m = 1'b1; wait_q(); wait_q();
            scl_m = 1'b0; wait_q();
        end
        bus_stop();
        wait_q();
        chk("R9", "aborted byte not written", 32'(got_fields()), 32'(exp_fields()));
        wbuf[0] = 8'h15;
        do_write(8'h84, 8'h02, 1, "R9 recovery after abort");

        // Random mix with a fixed seed
        dummy = $urandom(32'h5EED);
        for (int t = 0; t < 25; t++) begin
            if ($urandom % 4 == 0) begin
                det_sap = 1'($urandom); det_noise = 1'($urandom); det_stereo = 1'($urandom);
                do_read(1 + int'($urandom % 2), "R6 random read");
            end else begin
                logic [7:0] sub;
                logic [7:0] ab;
                int n;
                sub = ($urandom % 2 == 1) ? {4'($urandom), 4'($urandom % 5)} : 8'($urandom);
                ab  = ($urandom % 8 == 0) ? 8'h86 : 8'h84;
                n   = 1 + int'($urandom % 4);
                for (int i = 0; i < 8; i++) wbuf[i] = 8'($urandom);
                do_write(ab, sub, n, "R2 random write");
            end
        end

        chk("R8", "no drive while master sends", 32'(oe_bad), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule